// File: doc/BRIEF.md
# Pseudo-Random Noise Tone Generator

This block makes the raw one-bit waveform of a noise voice. A countdown timer runs on a system-rate enable. Each time the timer expires it reloads and advances a 15-bit linear feedback shift register. The bit shifted out of the register, inverted, is the waveform. Volume scaling, the note-length counter, the envelope and the register decode are all outside this block.

The timer period is a base divisor shifted left by a 4-bit shift amount. A 3-bit code selects the base divisor from a table that is not linear. A mode input shortens the sequence to 127 steps by writing the feedback into a second bit of the register. A trigger pulse restarts both the register and the timer. Changes to the code, the shift or the mode made while the voice plays do not restart anything. They are picked up at the next timer expiry.

Top module: `noise_tone_gen`

## Requirements
- R1: While `rst` is high and after it falls, with no trigger and no enable, `wave_out` is 0 (the register holds all ones). After reset the timer is empty, so the first enabled tick advances the register.
- R2: The timer period is B << `clk_shift` ticks of `tick_en`. B is 8 for `div_code` 0 and 16 × `div_code` for codes 1 to 7, which gives 8, 16, 32, 48, 64, 80, 96 and 112. After a trigger, the register advances on exactly every P-th tick, where P is the period computed at the most recent reload.
- R3: While `clk_shift` is 14 or 15 the register never advances. The timer still counts and reloads.
- R4: One advance computes f = bit0 XOR bit1, shifts the register right by one place, and puts f into bit 14.
- R5: When `short_mode` is 1 at an advance, f is also written into bit 6 after the shift.
- R6: `wave_out` is the inverse of register bit 0, and it is registered.
- R7: A cycle with `trig` high sets every register bit to 1 (so `wave_out` becomes 0) and loads the timer with the period of the current inputs. A trigger overrides a tick in the same cycle.
- R8: In a cycle with `tick_en` low and `trig` low, neither the timer nor the register changes.
- R9: A change to `div_code`, `clk_shift` or `short_mode` without a trigger keeps the register contents. New period values apply from the next reload. A mode change applies from the next advance.
- R10: In short mode, after a trigger, `wave_out` repeats every 127 advances. Over one such period it is 1 on 63 of the advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | System-rate enable that clocks the timer |
| trig | input | 1 | Restart pulse |
| div_code | input | 3 | Base divisor select |
| clk_shift | input | 4 | Left shift applied to the base divisor |
| short_mode | input | 1 | 1 selects the 127-step sequence |
| wave_out | output | 1 | Noise waveform bit |

## Verification
A fault in the register state shows at `wave_out` within a few advances. A wrong bit near the bottom shows on the next advance. A wrong high bit needs up to 14 advances to reach bit 0, or 6 advances in short mode. A fault in the timer does not show at once. It shows as an advance that comes too early or too late, so the bench compares the waveform with a tick-counting model on every cycle and can see a timing slip of a single cycle. The short-mode repeat check and the stopped-shift check need no model, so they guard against a model that is wrong in the same way as the design.

// File: rtl/noise_tone_pkg.sv
package noise_tone_pkg;

  // Width of the largest base divisor (112)
  localparam int BASE_W = 7;

  // Nonlinear base table: code 0 gives 8, every other code gives 16*code
  function automatic logic [BASE_W-1:0] base_divisor(input logic [2:0] code);
    logic [BASE_W-1:0] b;
    if (code == 3'd0) b = 7'd8;
    else              b = {code, 4'b0000};
    return b;
  endfunction

endpackage

// File: rtl/noise_period_calc.sv
module noise_period_calc #(
  parameter int SHIFT_W = 4,
  parameter int CNT_W   = 22
) (
  input  logic [2:0]         code_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [CNT_W-1:0]   period_o
);
  import noise_tone_pkg::*;

  logic [BASE_W-1:0] base;

  always_comb begin
    base     = base_divisor(code_i);
    period_o = CNT_W'(base) << shift_i;
  end

endmodule

// File: rtl/noise_divider.sv
module noise_divider #(
  parameter int SHIFT_W    = 4,
  parameter int CNT_W      = 22,
  parameter int STOP_SHIFT = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               trig_i,
  input  logic [CNT_W-1:0]   period_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               adv_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             expire;
  logic             stopped;

  assign expire  = tick_i && !trig_i && (cnt_q <= CNT_W'(1));
  assign stopped = (shift_i >= SHIFT_W'(STOP_SHIFT));
  assign adv_o   = expire && !stopped;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (trig_i) begin
      cnt_q <= period_i;
    end else if (tick_i) begin
      if (cnt_q <= CNT_W'(1)) cnt_q <= period_i;
      else                    cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R2: a tick that does not expire the timer lowers it by exactly one
  a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !trig_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R7: a trigger loads the period that was presented to the timer
  a_r7_trig_reload: assert property (@(posedge clk) disable iff (rst)
    trig_i |=> (cnt_q == $past(period_i)));

  // R8: with no tick and no trigger the timer holds
  a_r8_cnt_idle: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !trig_i) |=> $stable(cnt_q));

endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int LFSR_W    = 15,
  parameter int SHORT_TAP = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic              adv_i,
  input  logic              short_i,
  output logic              wave_o,
  output logic [LFSR_W-1:0] state_o
);

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] nxt;
  logic              fb;
  logic              wave_q;

  always_comb begin
    fb  = state_q[0] ^ state_q[1];
    nxt = {fb, state_q[LFSR_W-1:1]};
    if (short_i) nxt[SHORT_TAP] = fb;
  end

  always_ff @(posedge clk) begin
    if (rst || trig_i) begin
      state_q <= '1;
      wave_q  <= 1'b0;
    end else if (adv_i) begin
      state_q <= nxt;
      wave_q  <= ~nxt[0];
    end
  end

  assign wave_o  = wave_q;
  assign state_o = state_q;

  // R7: a trigger fills the register with ones and silences the output bit
  a_r7_trig_ones: assert property (@(posedge clk) disable iff (rst)
    trig_i |=> (state_q == '1 && wave_q == 1'b0));

  // R8: no advance and no trigger leave the register unchanged
  a_r8_state_hold: assert property (@(posedge clk) disable iff (rst)
    (!trig_i && !adv_i) |=> $stable(state_q));

  // R4: after an advance, the low bits are the old bits moved down one place
  // and the top bit is the old feedback
  a_r4_shift_right: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !trig_i) |=> (state_q[SHORT_TAP-1:0] == $past(state_q[SHORT_TAP:1])
      && state_q[LFSR_W-1] == ($past(state_q[0]) ^ $past(state_q[1]))));

  // R5: in short mode the second tap equals the new top bit
  a_r5_short_tap: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !trig_i && short_i) |=> (state_q[SHORT_TAP] == state_q[LFSR_W-1]));

  // R6: the output bit is always the inverse of bit 0
  a_r6_wave_inv: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (wave_q != state_q[0]));

endmodule

// File: rtl/noise_tone_gen.sv
module noise_tone_gen #(
  parameter int SHIFT_W    = 4,
  parameter int LFSR_W     = 15,
  parameter int SHORT_TAP  = 6,
  parameter int STOP_SHIFT = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               trig,
  input  logic [2:0]         div_code,
  input  logic [SHIFT_W-1:0] clk_shift,
  input  logic               short_mode,
  output logic               wave_out
);
  import noise_tone_pkg::*;

  localparam int CNT_W = BASE_W + (2 ** SHIFT_W) - 1;

  logic [CNT_W-1:0]  period;
  logic              adv;
  logic [LFSR_W-1:0] lfsr_state;

  noise_period_calc #(
    .SHIFT_W (SHIFT_W),
    .CNT_W   (CNT_W)
  ) u_period (
    .code_i   (div_code),
    .shift_i  (clk_shift),
    .period_o (period)
  );

  noise_divider #(
    .SHIFT_W    (SHIFT_W),
    .CNT_W      (CNT_W),
    .STOP_SHIFT (STOP_SHIFT)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_en),
    .trig_i   (trig),
    .period_i (period),
    .shift_i  (clk_shift),
    .adv_o    (adv)
  );

  noise_lfsr #(
    .LFSR_W    (LFSR_W),
    .SHORT_TAP (SHORT_TAP)
  ) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (trig),
    .adv_i   (adv),
    .short_i (short_mode),
    .wave_o  (wave_out),
    .state_o (lfsr_state)
  );

  // R3: a stop-range shift freezes the register whatever the timer does
  a_r3_stop_freeze: assert property (@(posedge clk) disable iff (rst)
    (clk_shift >= SHIFT_W'(STOP_SHIFT) && !trig) |=> $stable(lfsr_state));

endmodule

// File: tb/noise_tone_gen_tb.sv
`timescale 1ns/1ps
module noise_tone_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       trig = 1'b0;
  logic [2:0] div_code = 3'd0;
  logic [3:0] clk_shift = 4'd0;
  logic       short_mode = 1'b0;
  logic       wave_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [14:0] m_l;
  int unsigned m_cnt;
  string cur_tag = "R1";
  bit rec [0:2031];

  always #10 clk = ~clk;

  noise_tone_gen dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .trig(trig),
    .div_code(div_code), .clk_shift(clk_shift),
    .short_mode(short_mode), .wave_out(wave_out)
  );

  function automatic int unsigned per(input int code, input int sh);
    int unsigned b;
    b = (code == 0) ? 8 : 16 * code;
    return b << sh;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: update the reference from the inputs seen at the edge, compare
  task automatic cyc();
    logic f;
    @(posedge clk);
    #1;
    if (trig) begin
      m_l = '1;
      m_cnt = per(div_code, clk_shift);
    end else if (tick_en) begin
      if (m_cnt <= 1) begin
        m_cnt = per(div_code, clk_shift);
        if (clk_shift < 14) begin
          f = m_l[0] ^ m_l[1];
          m_l = {f, m_l[14:1]};
          if (short_mode) m_l[6] = f;
        end
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
    check(wave_out == ~m_l[0], cur_tag, wave_out, ~m_l[0]);
  endtask

  task automatic fire();
    trig = 1'b1;
    cyc();
    trig = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int ones;
    logic held;
    m_l = '1;
    m_cnt = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: output low in reset
    check(wave_out == 1'b0, "R1", wave_out, 0);
    rst = 1'b0;
    cur_tag = "R1";
    cyc();
    check(wave_out == 1'b0, "R1", wave_out, 0);

    // R2 R4 R5 R6: sweep divisor codes, two shifts, both modes, 20 advances each
    tick_en = 1'b1;
    for (int md = 0; md < 2; md++) begin
      for (int sh = 0; sh < 2; sh++) begin
        for (int c = 0; c < 8; c++) begin
          div_code = 3'(c);
          clk_shift = 4'(sh);
          short_mode = md[0];
          cur_tag = "R2 R4 R5 R6 R7";
          fire();
          for (int k = 0; k < int'(per(c, sh)) * 20; k++) cyc();
        end
      end
    end

    // R8: gapped enable, the timer and register hold on idle cycles
    cur_tag = "R8";
    div_code = 3'd1; clk_shift = 4'd0; short_mode = 1'b0;
    fire();
    for (int k = 0; k < 600; k++) begin
      tick_en = (k % 3 == 0);
      cyc();
    end
    tick_en = 1'b1;

    // R9: change mode and divisor mid-run without a trigger
    cur_tag = "R9";
    div_code = 3'd0;
    for (int k = 0; k < 100; k++) cyc();
    short_mode = 1'b1;
    div_code = 3'd2;
    for (int k = 0; k < 400; k++) cyc();
    short_mode = 1'b0;
    clk_shift = 4'd1;
    div_code = 3'd0;
    for (int k = 0; k < 400; k++) cyc();

    // R7: retrigger in the middle of a run, trigger wins over a tick
    cur_tag = "R7";
    fire();
    check(wave_out == 1'b0, "R7", wave_out, 0);
    for (int k = 0; k < 200; k++) cyc();

    // R3: stop-range shift freezes the waveform
    for (int sv = 14; sv < 16; sv++) begin
      cur_tag = "R3";
      clk_shift = 4'd0;
      div_code = 3'd0;
      for (int k = 0; k < 37; k++) cyc();
      clk_shift = 4'(sv);
      cyc();
      held = wave_out;
      for (int k = 0; k < 1500; k++) begin
        cyc();
        check(wave_out == held, "R3", wave_out, held);
      end
    end

    // R10: short sequence repeats every 127 advances
    cur_tag = "R10";
    clk_shift = 4'd0; div_code = 3'd0; short_mode = 1'b1;
    fire();
    for (int i = 0; i < 2032; i++) begin
      cyc();
      rec[i] = wave_out;
    end
    ones = 0;
    for (int i = 0; i < 1016; i++) begin
      check(rec[i] == rec[i + 1016], "R10", rec[i + 1016], rec[i]);
      if (rec[i]) ones++;
    end
    check(ones == 504, "R10", ones, 504);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule